// File: doc/BRIEF.md
# I2C Bit-Rate Divider

This block derives the bit timing of an I2C master from the core clock. It uses a two-stage divider. The first stage is a power-of-two prescaler whose length is set by a 3-bit exponent field. The second stage is a linear counter that runs over (M+1) prescaler terminals. Every completed pass of both stages produces one sub-bit tick. Ten ticks make one SCL period, which gives the fixed factor of ten in the bit rate. A phase counter walks through those ten ticks. It drives an SCL level that is low for the first five ticks and high for the last five, and it emits one-cycle strobes at the rising and falling SCL edges. A byte engine uses these strobes to place data and sample bits.

Software writes the exponent and linear fields through a small write port. A mode input chooses between two variants. In the default variant the exponent base adds one, so the prescaler length is 2^(N+1). In the alternate variant the prescaler length is 2^N. Settings written while the divider runs are held back. They take effect the next time the divider is idle. While idle, every counter sits at zero, so each run starts from a known phase.

Top module: `i2c_bitrate_gen`

## Requirements
- R1: The configuration word `cfg_wdata` carries the exponent N in bits [2:0] and the linear field M in bits [6:3]. Both fields are unsigned: M from 0 to 15 and N from 0 to 7.
- R2: With `alt_mode` low at run start, `sub_tick` pulses once every (M+1)*2^(N+1) core clocks. SCL therefore runs at core_clk / (10*(M+1)*2^(N+1)).
- R3: With `alt_mode` high at run start, `sub_tick` pulses once every (M+1)*2^N core clocks. With M=0 and N=0, `sub_tick` is high on every clock.
- R4: The first `sub_tick` of a run appears after the P-th rising clock edge that samples `run` high. P is the prescaler length: 2^(N+1), or 2^N in the alternate variant.
- R5: A `sub_tick` pulse lasts exactly one core clock, except at the setting whose tick period is one clock.
- R6: `phase` counts ticks modulo 10 and starts at 0. `scl_level` is low while `phase` is 0 to 4 and high while it is 5 to 9.
- R7: `scl_rise` pulses together with the tick that moves `phase` from 4 to 5. `scl_fall` pulses together with the tick that moves `phase` from 9 to 0.
- R8: One clock after `run` is sampled low, all counters are zero: `sub_tick`, `scl_rise` and `scl_fall` are low, `scl_level` is low and `phase` is 0.
- R9: A configuration write or a change of `alt_mode` made while `run` is high has no effect on the current run. The latest values take effect from the next run.
- R10: A synchronous active-low reset clears all outputs. It sets the configuration to M=0, N=0 with the default variant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the divider configuration |
| cfg_wdata | input | 7 | Configuration word: N in [2:0], M in [6:3] |
| alt_mode | input | 1 | High selects the 2^N prescaler variant |
| run | input | 1 | High runs the divider, low holds it idle at zero |
| sub_tick | output | 1 | One-clock tick at ten times the SCL rate |
| scl_level | output | 1 | SCL level the master should drive |
| scl_rise | output | 1 | Strobe on the tick where SCL goes high |
| scl_fall | output | 1 | Strobe on the tick where SCL goes low |
| phase | output | 4 | Sub-bit position within the SCL period, 0 to 9 |

## Verification
A prescaler or linear counter holding a wrong value shifts the next `sub_tick` by at least one clock. That shift shows up at the first tick of a run, or within one tick period after it. A corrupted phase counter shows up on the very next tick as a wrong `phase`, a misplaced SCL edge or a missing strobe. A configuration that is latched too early, during a run, changes the tick spacing within one period of the write. The bench compares every clock against the spacing computed from the fields, so any of these faults is reported within one tick period.

// File: rtl/i2c_brg_pkg.sv
`timescale 1ns/1ps
// Package: field widths and the latched configuration type of the
// I2C bit-rate divider. Assumes the exponent field sits below the
// linear field in the configuration word.
package i2c_brg_pkg;
    localparam int BRG_N_W   = 3;               // exponent field width
    localparam int BRG_M_W   = 4;               // linear field width
    localparam int BRG_EXP_W = BRG_N_W + 1;     // exponent plus variant offset
    localparam int BRG_PRE_W = 1 << BRG_N_W;    // prescaler counter width

    typedef struct packed {
        logic               alt;  // 1: 2^N prescaler, 0: 2^(N+1)
        logic [BRG_M_W-1:0] m;
        logic [BRG_N_W-1:0] n;
    } brg_cfg_t;
endpackage

// File: rtl/brg_cfg_hold.sv
`timescale 1ns/1ps
// brg_cfg_hold: captures configuration writes and the variant select
// into a pending copy, and moves the pending copy into the active copy
// only while the divider is idle. Assumes run is synchronous to clk.
module brg_cfg_hold
    import i2c_brg_pkg::*;
#(
    parameter int CFG_W = BRG_N_W + BRG_M_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    input  logic             alt_in,
    input  logic             run,
    output brg_cfg_t         act
);
    brg_cfg_t pend_q;
    brg_cfg_t pend_d;
    brg_cfg_t act_q;

    // Next pending value: a write replaces both fields, the mode is followed live.
    always_comb begin
        pend_d     = pend_q;
        pend_d.alt = alt_in;
        if (we) begin
            pend_d.n = wdata[BRG_N_W-1:0];
            pend_d.m = wdata[BRG_N_W +: BRG_M_W];
        end
    end

    // Pending copy always updates; active copy only loads while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            act_q  <= '0;
        end else begin
            pend_q <= pend_d;
            if (!run) begin
                act_q <= pend_d;
            end
        end
    end

    assign act = act_q;
endmodule

// File: rtl/brg_pow2_prescale.sv
`timescale 1ns/1ps
// brg_pow2_prescale: power-of-two prescaler. Its length is 2^(N+1) in
// the default variant and 2^N in the alternate one. Asserts term for one
// clock at the last count. Assumes n and alt are stable while run is high.
module brg_pow2_prescale
    import i2c_brg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic                 alt,
    input  logic [BRG_N_W-1:0]   n,
    output logic                 term,
    output logic [BRG_PRE_W-1:0] cnt,
    output logic [BRG_PRE_W-1:0] limit
);
    logic [BRG_EXP_W-1:0] expo;
    logic [BRG_PRE_W-1:0] cnt_q;

    // Effective exponent: N, plus one for the default variant.
    assign expo = {1'b0, n} + {{(BRG_EXP_W-1){1'b0}}, ~alt};

    // Terminal count is 2^expo - 1: one mask bit per position below expo.
    for (genvar i = 0; i < BRG_PRE_W; i++) begin : g_mask
        assign limit[i] = (BRG_EXP_W'(i) < expo);
    end

    assign term = run && (cnt_q == limit);

    // Count up to the limit, wrap to zero; held at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (term) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + BRG_PRE_W'(1);
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/brg_lin_stage.sv
`timescale 1ns/1ps
// brg_lin_stage: linear (M+1) stage. A down counter steps on each
// prescaler terminal. At zero it raises adv and reloads M. Assumes m is
// stable while run is high.
module brg_lin_stage
    import i2c_brg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               pre_term,
    input  logic [BRG_M_W-1:0] m,
    output logic               adv,
    output logic [BRG_M_W-1:0] cnt
);
    logic [BRG_M_W-1:0] cnt_q;

    assign adv = pre_term && (cnt_q == '0);

    // Decrement per prescaler terminal, reload M at zero, clear while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (pre_term) begin
            cnt_q <= (cnt_q == '0) ? m : cnt_q - BRG_M_W'(1);
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/brg_scl_phase.sv
`timescale 1ns/1ps
// brg_scl_phase: turns divider advances into registered sub-bit ticks,
// a phase index modulo SUB_TICKS, the SCL level (low for the first half,
// high for the second) and one-clock edge strobes. Assumes SUB_TICKS is
// even and at least 2.
module brg_scl_phase #(
    parameter int SUB_TICKS = 10,
    localparam int PH_W = $clog2(SUB_TICKS),
    localparam int HALF = SUB_TICKS / 2,
    localparam int LAST = SUB_TICKS - 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            adv,
    output logic            tick,
    output logic            scl,
    output logic            rise,
    output logic            fall,
    output logic [PH_W-1:0] phase
);
    logic [PH_W-1:0] ph_q;
    logic [PH_W-1:0] ph_d;
    logic            tick_q;
    logic            scl_q;
    logic            rise_q;
    logic            fall_q;

    // Next phase: advance on each tick, wrap after the last sub-tick.
    always_comb begin
        ph_d = ph_q;
        if (adv) begin
            ph_d = (ph_q == PH_W'(LAST)) ? '0 : ph_q + PH_W'(1);
        end
    end

    // Register phase, tick, level and strobes; all cleared while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ph_q   <= '0;
            tick_q <= 1'b0;
            scl_q  <= 1'b0;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            ph_q   <= ph_d;
            tick_q <= adv;
            scl_q  <= (ph_d >= PH_W'(HALF));
            rise_q <= adv && (ph_q == PH_W'(HALF - 1));
            fall_q <= adv && (ph_q == PH_W'(LAST));
        end
    end

    assign tick  = tick_q;
    assign scl   = scl_q;
    assign rise  = rise_q;
    assign fall  = fall_q;
    assign phase = ph_q;
endmodule

// File: rtl/i2c_bitrate_gen.sv
`timescale 1ns/1ps
// i2c_bitrate_gen: top of the I2C bit-rate divider. It chains the
// configuration holder, the power-of-two prescaler, the linear stage and
// the SCL phase generator. Assumes all inputs are synchronous to clk.
module i2c_bitrate_gen
    import i2c_brg_pkg::*;
#(
    parameter int SUB_TICKS = 10,
    localparam int PH_W  = $clog2(SUB_TICKS),
    localparam int CFG_W = BRG_N_W + BRG_M_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             alt_mode,
    input  logic             run,
    output logic             sub_tick,
    output logic             scl_level,
    output logic             scl_rise,
    output logic             scl_fall,
    output logic [PH_W-1:0]  phase
);
    brg_cfg_t             cfg_act;
    logic                 pre_term;
    logic [BRG_PRE_W-1:0] pre_cnt;
    logic [BRG_PRE_W-1:0] pre_lim;
    logic                 adv;
    logic [BRG_M_W-1:0]   lin_cnt;

    brg_cfg_hold #(.CFG_W(CFG_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .alt_in (alt_mode),
        .run    (run),
        .act    (cfg_act)
    );

    brg_pow2_prescale u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .alt   (cfg_act.alt),
        .n     (cfg_act.n),
        .term  (pre_term),
        .cnt   (pre_cnt),
        .limit (pre_lim)
    );

    brg_lin_stage u_lin (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .pre_term (pre_term),
        .m        (cfg_act.m),
        .adv      (adv),
        .cnt      (lin_cnt)
    );

    brg_scl_phase #(.SUB_TICKS(SUB_TICKS)) u_ph (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .adv   (adv),
        .tick  (sub_tick),
        .scl   (scl_level),
        .rise  (scl_rise),
        .fall  (scl_fall),
        .phase (phase)
    );
endmodule

// File: rtl/brg_chk.sv
`timescale 1ns/1ps
// brg_chk: property checker for i2c_bitrate_gen. It watches the ports and
// the stage counters. It is attached by the bind at the end of this file.
module brg_chk
    import i2c_brg_pkg::*;
#(
    parameter int SUB_TICKS = 10,
    localparam int PH_W = $clog2(SUB_TICKS),
    localparam int HALF = SUB_TICKS / 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 run,
    input logic                 sub_tick,
    input logic                 scl_level,
    input logic                 scl_rise,
    input logic                 scl_fall,
    input logic [PH_W-1:0]      phase,
    input logic [BRG_PRE_W-1:0] pre_cnt,
    input logic [BRG_PRE_W-1:0] pre_lim,
    input logic [BRG_M_W-1:0]   lin_cnt,
    input brg_cfg_t             cfg_act
);
    // R8: an idle cycle clears every counter and output on the next clock.
    a_r8_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!sub_tick && !scl_level && !scl_rise && !scl_fall &&
                  phase == '0 && pre_cnt == '0 && lin_cnt == '0));

    // R2: the prescaler never passes its power-of-two limit.
    a_r2_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pre_cnt <= pre_lim);

    // R3: the linear stage never passes M.
    a_r3_lin_bound: assert property (@(posedge clk) disable iff (!rst_n)
        lin_cnt <= cfg_act.m);

    // R5: a tick is one clock wide unless the tick period is one clock.
    a_r5_tick_width: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_tick && !(cfg_act.m == '0 && pre_lim == '0)) |=> !sub_tick);

    // R6: the phase stays in range and the SCL level follows its half.
    a_r6_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        phase < PH_W'(SUB_TICKS));
    a_r6_scl_half: assert property (@(posedge clk) disable iff (!rst_n)
        scl_level == (phase >= PH_W'(HALF)));

    // R7: edge strobes only come with a tick and match the new level.
    a_r7_rise_tick: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise |-> (sub_tick && scl_level));
    a_r7_fall_tick: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall |-> (sub_tick && !scl_level));

    // R9: the active configuration holds still through a run.
    a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> $stable(cfg_act));
endmodule

bind i2c_bitrate_gen brg_chk #(.SUB_TICKS(SUB_TICKS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .sub_tick  (sub_tick),
    .scl_level (scl_level),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .phase     (phase),
    .pre_cnt   (pre_cnt),
    .pre_lim   (pre_lim),
    .lin_cnt   (lin_cnt),
    .cfg_act   (cfg_act)
);

// File: tb/sim_i2c_bitrate_gen.sv
`timescale 1ns/1ps
// Bench for i2c_bitrate_gen: directed corner settings plus seeded random
// settings. Expected tick times come from the divider formulas.
module sim_i2c_bitrate_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [6:0] cfg_wdata = '0;
    logic       alt_mode = 1'b0;
    logic       run = 1'b0;
    logic       sub_tick;
    logic       scl_level;
    logic       scl_rise;
    logic       scl_fall;
    logic [3:0] phase;

    int vec = 0;
    int bad = 0;

    i2c_bitrate_gen u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .alt_mode  (alt_mode),
        .run       (run),
        .sub_tick  (sub_tick),
        .scl_level (scl_level),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .phase     (phase)
    );

    always #10 clk = ~clk;  // 50 MHz

    task automatic chk(string req, int act, int exp);
        vec++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int pre_len(int n, bit alt);
        return 1 << (n + (alt ? 0 : 1));
    endfunction

    function automatic int tick_period(int m, int n, bit alt);
        return (m + 1) * pre_len(n, alt);
    endfunction

    task automatic idle_check(string req);
        chk({req, " tick"}, sub_tick, 0);
        chk({req, " scl"}, scl_level, 0);
        chk({req, " rise"}, scl_rise, 0);
        chk({req, " fall"}, scl_fall, 0);
        chk({req, " phase"}, phase, 0);
    endtask

    // Runs the divider with setting (m,n,alt) for nticks ticks and checks
    // every clock. wr=0 reuses the pending setting; midwr writes m=7,n=3
    // and flips the mode during the run (R9).
    task automatic trial(int m, int n, bit alt, int nticks, bit wr, bit midwr);
        int p, per, total, cnt, ph;
        bit et;
        string tag;
        if (wr) begin
            @(negedge clk);
            cfg_we    = 1'b1;
            cfg_wdata = {m[3:0], n[2:0]};  // R1: N in [2:0], M in [6:3]
            alt_mode  = alt;
            @(negedge clk);
            cfg_we = 1'b0;
        end
        @(negedge clk);
        run   = 1'b1;
        p     = pre_len(n, alt);
        per   = tick_period(m, n, alt);
        total = p + per * (nticks - 1);
        cnt   = 0;
        for (int e = 1; e <= total; e++) begin
            @(posedge clk);
            @(negedge clk);
            if (midwr && e == 3) cfg_we = 1'b0;
            et = (e >= p) && (((e - p) % per) == 0);
            if (et) cnt++;
            ph = cnt % 10;
            if (e <= p)       tag = "R4 first tick";
            else if (!et)     tag = "R5 no tick";
            else if (alt)     tag = "R3 tick";
            else              tag = "R2 tick";
            chk(tag, sub_tick, et);
            chk("R6 phase", phase, ph);
            chk("R6 scl", scl_level, (ph >= 5) ? 1 : 0);
            chk("R7 rise", scl_rise, (et && ph == 5) ? 1 : 0);
            chk("R7 fall", scl_fall, (et && ph == 0) ? 1 : 0);
            if (midwr && e == 2) begin
                cfg_we    = 1'b1;
                cfg_wdata = {4'd7, 3'd3};
                alt_mode  = !alt;
            end
        end
        run = 1'b0;
        @(posedge clk);
        @(negedge clk);
        idle_check("R8 idle");
        @(negedge clk);
    endtask

    initial begin : main
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        idle_check("R10 reset");
        rst_n = 1'b1;
        @(negedge clk);
        idle_check("R10 after reset");
        // R10: default setting M=0,N=0, default variant, with no write.
        trial(0, 0, 0, 12, 1'b0, 1'b0);
        // R3: fastest legal setting, tick every clock.
        trial(0, 0, 1, 25, 1'b1, 1'b0);
        // R1: fields in distinct positions give distinct periods.
        trial(1, 2, 0, 12, 1'b1, 1'b0);
        trial(2, 1, 1, 12, 1'b1, 1'b0);
        // R2/R3: largest exponents.
        trial(1, 7, 0, 3, 1'b1, 1'b0);
        trial(15, 7, 1, 2, 1'b1, 1'b0);
        // R9: write during run is deferred, then applies to the next run.
        trial(2, 1, 0, 12, 1'b1, 1'b1);
        trial(7, 3, 1, 11, 1'b0, 1'b0);
        // Seeded random settings.
        for (int t = 0; t < 12; t++) begin
            int rm, rn;
            bit ra;
            rm = int'($urandom % 16);
            rn = int'($urandom % 4);
            ra = 1'($urandom % 2);
            trial(rm, rn, ra, 12, 1'b1, 1'b0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin : watchdog
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule